// File: doc/BRIEF.md
# JTAG Debug Port Access Register Block

This block is the target-side logic of a debug port that sits behind an external JTAG TAP controller. The TAP supplies the current instruction and three one-cycle strobes: capture, shift and update. Four instructions select a data register. One is a 32-bit identification register. One is an abort register. The other two are access registers, one for the port's own registers and one for an access port. Any other instruction selects a 1-bit bypass stage.

An access scan moves a 35-bit frame, least significant bit first. On capture the frame is loaded with a 3-bit acknowledge and the 32-bit read buffer. The read buffer holds the result of an earlier posted read, not the one requested in the same scan. On update the request in the frame is carried out. Port-side requests cover a control/status word with sticky flags, a select word and the read buffer. Access-port requests go to a stub access port that finishes after a programmable number of cycles. While that stub is busy, a scan returns a WAIT acknowledge and its request is dropped. If overrun detection is on, that dropped request also sets a sticky overrun flag.

Top module: `dbgp_jtag_port`

## Requirements
- R1: Instruction 0xE selects a 32-bit register that captures IDCODE_VAL, with bit 0 set. Any instruction other than 0x8, 0xA, 0xB and 0xE selects a 1-bit register that captures 0.
- R2: Instructions 0xA (port access) and 0xB (access-port access) shift a 35-bit frame, LSB first. Frame bit 0 is the read flag (1 = read), bits 2:1 are the register address A, and bits 34:3 are the write data.
- R3: On capture of an access frame, bits 2:0 hold 3'b010 (OK) when the access port is idle and 3'b001 (WAIT) when it is busy.
- R4: Frame bits 34:3 captured by an access scan are the read buffer. A port-register read loads the buffer at update. An access-port read loads it AP_LATENCY cycles after update.
- R5: A port read of A=3 returns the read buffer and leaves it unchanged.
- R6: A scan whose acknowledge was WAIT has its request dropped. If the overrun-enable bit is set, that scan's update sets the sticky overrun flag.
- R7: While the overrun flag or the error flag is set, access-port requests are discarded. Writing a 1 to a flag's bit in the control word clears that flag.
- R8: The select word sits at port address A=2 and reads back as {24'b0, select[7:0]}. Select bits 7:4 give access-port address bits 5:2, and frame A gives bits 1:0. Select bits 3:0 give the access-port number. An access-port request with a nonzero number sets the sticky error flag and does nothing else.
- R9: The control word sits at port address A=1. It reads {26'b0, error flag at bit 5, 3'b0, overrun flag at bit 1, overrun enable at bit 0}. Bit 0 can be read and written. A port read of A=0 returns 0.
- R10: An update of instruction 0x8 whose frame bit 3 (data bit 0) is 1 cancels the pending access-port transaction. The write is not done, the read buffer is not loaded, and the port is idle after that edge.
- R11: After reset the read buffer, control word, select word and all access-port registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TAP clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_sel | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture strobe for the selected data register |
| shift_dr | input | 1 | Shift strobe, one bit per cycle |
| update_dr | input | 1 | Update strobe that carries out the scanned request |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, the current LSB of the shift register |

## Verification
Random sequences mix access-port writes and reads across random banks, select rewrites, control writes with random flag-clear bits, and port reads of every address. This shows that posted data is always one request behind and that bank bits steer the address. Directed cases follow. A scan started one cycle after an access-port request separates OK from WAIT and shows the overrun flag being set. A write made while a sticky flag is set is later read back unchanged, which shows it was discarded. An abort issued inside the latency window shows that neither the write nor the busy state survives. A nonzero access-port number separates the error flag from the overrun flag.

// File: rtl/dbgp_pkg.sv
// Shared constants and the access frame layout for the debug port.
package dbgp_pkg;
    localparam logic [3:0] IR_ABORT  = 4'h8;
    localparam logic [3:0] IR_DPACC  = 4'hA;
    localparam logic [3:0] IR_APACC  = 4'hB;
    localparam logic [3:0] IR_IDCODE = 4'hE;

    localparam int DATA_W  = 32;
    localparam int HDR_W   = 3;
    localparam int FRAME_W = DATA_W + HDR_W;
    localparam int BANK_W  = 4;
    localparam int AP_AW   = BANK_W + 2;

    localparam logic [2:0] ACK_OK   = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;

    // Frame as shifted: read flag in bit 0, address in 2:1, data above.
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [1:0]        a;
        logic              rnw;
    } frame_t;

    function automatic logic is_access(input logic [3:0] ir);
        return (ir == IR_DPACC) || (ir == IR_APACC);
    endfunction
endpackage

// File: rtl/dbgp_shifter.sv
// Data-register shift path. Loads the selected register on capture and
// shifts it LSB first. Assumes capture, shift and update come from an
// external TAP controller and are never active together.
module dbgp_shifter
    import dbgp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h0C0D_E5A1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         ir_sel,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               tdi,
    input  logic [2:0]         ack,
    input  logic [DATA_W-1:0]  rdbuf,
    output logic [FRAME_W-1:0] shreg,
    output logic               tdo
);
    logic long_frame;
    assign long_frame = is_access(ir_sel) || (ir_sel == IR_ABORT);

    // Capture the selected register, then move one bit per shift cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (capture_dr) begin
            if (long_frame)
                shreg <= {rdbuf, ack};
            else if (ir_sel == IR_IDCODE)
                shreg <= {{HDR_W{1'b0}}, IDCODE_VAL};
            else
                shreg <= '0;
        end else if (shift_dr) begin
            if (long_frame)
                shreg <= {tdi, shreg[FRAME_W-1:1]};
            else if (ir_sel == IR_IDCODE)
                shreg <= {{HDR_W{1'b0}}, tdi, shreg[DATA_W-1:1]};
            else
                shreg <= {{(FRAME_W-1){1'b0}}, tdi};
        end
    end

    assign tdo = shreg[0];
endmodule

// File: rtl/dbgp_ap_stub.sv
// Stand-in access port: a small register file whose accesses finish
// LATENCY cycles after the request. Assumes a new request only arrives
// when idle; an abort drops the pending access.
module dbgp_ap_stub
    import dbgp_pkg::*;
#(
    parameter int LATENCY = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_rnw,
    input  logic [AP_AW-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              abort,
    output logic              busy,
    output logic              rd_done,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam int DEPTH = 1 << AP_AW;

    logic [CNT_W-1:0]  cnt;
    logic              p_rnw;
    logic [AP_AW-1:0]  p_addr;
    logic [DATA_W-1:0] p_wdata;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              finish;

    assign busy    = (cnt != '0);
    assign finish  = (cnt == CNT_W'(1)) && !abort;
    assign rd_done = finish && p_rnw;
    assign rdata   = mem[p_addr];

    // Latency counter and latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            p_rnw   <= 1'b0;
            p_addr  <= '0;
            p_wdata <= '0;
        end else if (abort) begin
            cnt <= '0;
        end else if (req && !busy) begin
            cnt     <= CNT_W'(LATENCY);
            p_rnw   <= req_rnw;
            p_addr  <= req_addr;
            p_wdata <= req_wdata;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Register file, written when a write access completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (finish && !p_rnw) begin
            mem[p_addr] <= p_wdata;
        end
    end
endmodule

// File: rtl/dbgp_dp_regs.sv
// Port-side registers: control/status flags, select word, read buffer,
// and the decode of each update into a port or access-port action.
// Assumes the frame is stable from the last shift through update.
module dbgp_dp_regs
    import dbgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ir_sel,
    input  logic              capture_dr,
    input  logic              update_dr,
    input  frame_t            frame,
    input  logic              ap_busy,
    input  logic              ap_rd_done,
    input  logic [DATA_W-1:0] ap_rdata,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdbuf,
    output logic              ap_req,
    output logic [AP_AW-1:0]  ap_addr,
    output logic              ap_abort,
    output logic              wait_q,
    output logic              orun_en,
    output logic              sorun,
    output logic              serr
);
    logic [7:0]        sel;
    logic              upd_ok, dp_upd, ap_upd, sticky, bad_ap;
    logic [DATA_W-1:0] ctrl_word;

    assign ack       = ap_busy ? ACK_WAIT : ACK_OK;
    assign upd_ok    = update_dr && !wait_q;
    assign dp_upd    = upd_ok && (ir_sel == IR_DPACC);
    assign ap_upd    = upd_ok && (ir_sel == IR_APACC);
    assign sticky    = sorun || serr;
    assign bad_ap    = (sel[3:0] != 4'h0);
    assign ap_req    = ap_upd && !sticky && !bad_ap;
    assign ap_addr   = {sel[7:4], frame.a};
    assign ap_abort  = update_dr && (ir_sel == IR_ABORT) && frame.data[0];
    assign ctrl_word = {26'b0, serr, 3'b0, sorun, orun_en};

    // Remember whether the current access scan was answered with WAIT.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= 1'b0;
        else if (capture_dr && is_access(ir_sel))
            wait_q <= ap_busy;
    end

    // Control flags: overrun enable, sticky overrun and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orun_en <= 1'b0;
            sorun   <= 1'b0;
            serr    <= 1'b0;
        end else begin
            if (update_dr && is_access(ir_sel) && wait_q && orun_en)
                sorun <= 1'b1;
            if (dp_upd && !frame.rnw && frame.a == 2'd1) begin
                orun_en <= frame.data[0];
                if (frame.data[1]) sorun <= 1'b0;
                if (frame.data[5]) serr  <= 1'b0;
            end
            if (ap_upd && !sticky && bad_ap)
                serr <= 1'b1;
        end
    end

    // Select word written by port writes to address 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (dp_upd && !frame.rnw && frame.a == 2'd2)
            sel <= frame.data[7:0];
    end

    // Read buffer: completed access-port reads, then port reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdbuf <= '0;
        end else if (ap_rd_done) begin
            rdbuf <= ap_rdata;
        end else if (dp_upd && frame.rnw) begin
            case (frame.a)
                2'd0:    rdbuf <= '0;
                2'd1:    rdbuf <= ctrl_word;
                2'd2:    rdbuf <= {24'b0, sel};
                default: rdbuf <= rdbuf;
            endcase
        end
    end
endmodule

// File: rtl/dbgp_jtag_port.sv
// Top of the debug port: shift path, port registers and stub access
// port. Assumes an external TAP drives ir_sel and the three strobes.
module dbgp_jtag_port
    import dbgp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h0C0D_E5A1,
    parameter int          AP_LATENCY = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ir_sel,
    input  logic       capture_dr,
    input  logic       shift_dr,
    input  logic       update_dr,
    input  logic       tdi,
    output logic       tdo
);
    logic [FRAME_W-1:0] shreg;
    logic [2:0]         ack;
    logic [DATA_W-1:0]  rdbuf, ap_rdata;
    logic               ap_req, ap_abort, ap_busy, ap_rd_done;
    logic [AP_AW-1:0]   ap_addr;
    logic               wait_q, orun_en, sorun, serr;
    frame_t             frame;

    assign frame = frame_t'(shreg);

    dbgp_shifter #(.IDCODE_VAL(IDCODE_VAL)) u_shift (
        .clk(clk), .rst_n(rst_n), .ir_sel(ir_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .tdi(tdi),
        .ack(ack), .rdbuf(rdbuf), .shreg(shreg), .tdo(tdo)
    );

    dbgp_dp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ir_sel(ir_sel),
        .capture_dr(capture_dr), .update_dr(update_dr), .frame(frame),
        .ap_busy(ap_busy), .ap_rd_done(ap_rd_done), .ap_rdata(ap_rdata),
        .ack(ack), .rdbuf(rdbuf), .ap_req(ap_req), .ap_addr(ap_addr),
        .ap_abort(ap_abort), .wait_q(wait_q), .orun_en(orun_en),
        .sorun(sorun), .serr(serr)
    );

    dbgp_ap_stub #(.LATENCY(AP_LATENCY)) u_ap (
        .clk(clk), .rst_n(rst_n), .req(ap_req), .req_rnw(frame.rnw),
        .req_addr(ap_addr), .req_wdata(frame.data), .abort(ap_abort),
        .busy(ap_busy), .rd_done(ap_rd_done), .rdata(ap_rdata)
    );
endmodule

// File: rtl/dbgp_jtag_port_chk.sv
// Property checker for dbgp_jtag_port, attached by bind below.
module dbgp_jtag_port_chk
    import dbgp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h0C0D_E5A1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  ir_sel,
    input logic        capture_dr,
    input logic        update_dr,
    input logic [31:0] shreg,
    input logic        ap_busy,
    input logic        wait_q,
    input logic        orun_en,
    input logic        sorun,
    input logic        serr
);
    AST_IDCODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && ir_sel == IR_IDCODE |=> shreg == IDCODE_VAL); // R1

    AST_ACK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && is_access(ir_sel) && ap_busy |=> shreg[2:0] == ACK_WAIT); // R3

    AST_ACK_OK: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && is_access(ir_sel) && !ap_busy |=> shreg[2:0] == ACK_OK); // R3

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        update_dr && is_access(ir_sel) && wait_q && orun_en |=> sorun); // R6

    AST_STICKY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sorun || serr) && !ap_busy |=> !ap_busy); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        update_dr && ir_sel == IR_ABORT && shreg[3] |=> !ap_busy); // R10
endmodule

bind dbgp_jtag_port dbgp_jtag_port_chk #(.IDCODE_VAL(IDCODE_VAL)) u_chk (
    .clk(clk), .rst_n(rst_n), .ir_sel(ir_sel), .capture_dr(capture_dr),
    .update_dr(update_dr), .shreg(shreg[31:0]), .ap_busy(ap_busy),
    .wait_q(wait_q), .orun_en(orun_en), .sorun(sorun), .serr(serr)
);

// File: tb/sim_dbgp_jtag_port.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, all
// checked against a behavioural model of the port.
module sim_dbgp_jtag_port;
    localparam logic [31:0] IDV = 32'h0C0D_E5A1;
    localparam int LAT = 40;
    localparam logic [2:0] OK = 3'b010, WT = 3'b001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] ir_sel = 4'h0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic tdo;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Behavioural model state.
    logic [31:0] m_mem [64];
    logic [31:0] m_rdbuf;
    logic [7:0]  m_sel;
    logic        m_en, m_sorun, m_serr;

    always #2.5 clk = ~clk;

    dbgp_jtag_port #(.IDCODE_VAL(IDV), .AP_LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .ir_sel(ir_sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_ctrl();
        return {26'b0, m_serr, 3'b0, m_sorun, m_en};
    endfunction

    task automatic scan(input logic [3:0] ir, input int len, input logic [34:0] din,
                        output logic [34:0] dout);
        dout = '0;
        @(negedge clk); ir_sel = ir; capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge clk); update_dr = 1'b0;
    endtask

    task automatic settle();
        repeat (LAT + 2) @(negedge clk);
    endtask

    // One access scan with ack/data checks and the matching model update.
    task automatic acc(input bit ap, input logic [1:0] a, input bit rnw,
                       input logic [31:0] d, input logic [2:0] eack,
                       input bit skip_model, input string req);
        logic [34:0] q;
        scan(ap ? 4'hB : 4'hA, 35, {d, a, rnw}, q);
        check(q[2:0] == eack, {req, " R3 ack"}, 32'(q[2:0]), 32'(eack));
        if (eack == OK)
            check(q[34:3] == m_rdbuf, {req, " R4 posted data"}, q[34:3], m_rdbuf);
        if (skip_model) return;
        if (eack == WT) begin
            if (m_en) m_sorun = 1'b1;
        end else if (!ap) begin
            if (rnw) begin
                case (a)
                    2'd0: m_rdbuf = '0;
                    2'd1: m_rdbuf = m_ctrl();
                    2'd2: m_rdbuf = {24'b0, m_sel};
                    default: ;
                endcase
            end else if (a == 2'd1) begin
                m_en = d[0];
                if (d[1]) m_sorun = 1'b0;
                if (d[5]) m_serr = 1'b0;
            end else if (a == 2'd2) begin
                m_sel = d[7:0];
            end
        end else if (!(m_sorun || m_serr)) begin
            if (m_sel[3:0] != 4'h0) m_serr = 1'b1;
            else if (rnw) m_rdbuf = m_mem[{m_sel[7:4], a}];
            else m_mem[{m_sel[7:4], a}] = d;
        end
    endtask

    initial begin
        logic [34:0] q;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        m_rdbuf = '0; m_sel = '0; m_en = 1'b0; m_sorun = 1'b0; m_serr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state: read buffer and control word are zero.
        check(tdo == 1'b0, "R11 tdo after reset", 32'(tdo), 0);
        acc(0, 2'd1, 1, 0, OK, 0, "R11 ctrl read");
        acc(0, 2'd3, 1, 0, OK, 0, "R11 ctrl zero via R5 rdbuf");
        acc(0, 2'd0, 1, 0, OK, 0, "R9 addr0 read");
        acc(0, 2'd3, 1, 0, OK, 0, "R9 addr0 gives zero");

        // R1 identification and bypass.
        scan(4'hE, 32, 35'h0, q);
        check(q[31:0] == IDV, "R1 idcode", q[31:0], IDV);
        scan(4'h3, 1, 35'h1, q);
        check(q[0] == 1'b0, "R1 bypass captures 0", 32'(q[0]), 0);

        // R2/R4/R5/R8: banked write, posted read, repeat rdbuf reads.
        acc(0, 2'd2, 0, 32'h0000_0020, OK, 0, "R8 select bank 2");
        acc(0, 2'd2, 1, 0, OK, 0, "R8 select read");
        acc(0, 2'd3, 1, 0, OK, 0, "R8 select readback");
        acc(1, 2'd1, 0, 32'hA5A5_1234, OK, 0, "R2 ap write"); settle();
        acc(1, 2'd1, 1, 0, OK, 0, "R4 ap read"); settle();
        acc(0, 2'd3, 1, 0, OK, 0, "R4 ap read result");
        acc(0, 2'd3, 1, 0, OK, 0, "R5 rdbuf unchanged");

        // R3/R6: WAIT on a busy port, overrun set, request dropped.
        acc(0, 2'd1, 0, 32'h1, OK, 0, "R9 enable overrun");
        acc(1, 2'd1, 1, 0, OK, 0, "R6 ap read");
        acc(0, 2'd2, 0, 32'h0000_0030, WT, 0, "R6 busy select write"); settle();
        acc(0, 2'd2, 1, 0, OK, 0, "R6 select kept");
        acc(0, 2'd1, 1, 0, OK, 0, "R6 select value");
        acc(0, 2'd3, 1, 0, OK, 0, "R6 overrun flag");

        // R7: discarded while sticky, then cleared.
        acc(1, 2'd1, 0, 32'hDEAD_0001, OK, 0, "R7 write while sticky"); settle();
        acc(0, 2'd1, 0, 32'h3, OK, 0, "R7 clear overrun");
        acc(1, 2'd1, 1, 0, OK, 0, "R7 read back"); settle();
        acc(0, 2'd3, 1, 0, OK, 0, "R7 old value kept");

        // R10: abort inside the latency window.
        acc(1, 2'd1, 0, 32'h5555_AAAA, OK, 1, "R10 ap write");
        scan(4'h8, 35, {32'h1, 3'b000}, q);
        acc(0, 2'd1, 1, 0, OK, 0, "R10 idle after abort");
        acc(1, 2'd1, 1, 0, OK, 0, "R10 read back"); settle();
        acc(0, 2'd3, 1, 0, OK, 0, "R10 write cancelled");

        // R8: nonzero access-port number sets the error flag.
        acc(0, 2'd2, 0, 32'h0000_0021, OK, 0, "R8 ap number 1");
        acc(1, 2'd0, 0, 32'h7, OK, 0, "R8 bad ap write"); settle();
        acc(0, 2'd1, 1, 0, OK, 0, "R8 ctrl read");
        acc(0, 2'd3, 1, 0, OK, 0, "R8 error flag");
        acc(0, 2'd1, 0, 32'h21, OK, 0, "R7 clear error");

        // Random traffic against the model.
        for (int k = 0; k < 120; k++) begin
            int op;
            logic [31:0] rd;
            op = int'($urandom % 8);
            rd = $urandom;
            case (op)
                0, 1, 2: acc(1, rd[1:0], 0, $urandom, OK, 0, "R2 rnd ap write");
                3, 4:    acc(1, rd[1:0], 1, 0, OK, 0, "R4 rnd ap read");
                5:       acc(0, 2'd2, 0, {24'b0, rd[7:4], ($urandom % 8 == 0) ? 4'h1 : 4'h0},
                             OK, 0, "R8 rnd select");
                6:       acc(0, 2'd1, 0, rd & 32'h23, OK, 0, "R9 rnd ctrl");
                default: acc(0, rd[1:0], 1, 0, OK, 0, "R5 rnd dp read");
            endcase
            settle();
        end
        acc(0, 2'd3, 1, 0, OK, 0, "R4 final rdbuf");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule